// File: doc/BRIEF.md
# Underflow-Tolerant Transmit Sample Buffer

This block sits in front of a DAC that must receive exactly one sample on every sample-enable strobe, while samples arrive from the host in bursts with irregular spacing. Incoming 32-bit complex samples (16-bit I and Q packed in one word) are queued in a first-in first-out store. Each strobe takes the oldest stored sample and presents it on a registered output.

When the store is empty at a strobe, the block emits a fill sample instead of stalling. The fill sample is either zero or a repeat of the last real sample, selected by a mode input. The block also records how many fill samples it has inserted. When late data finally arrives, it drops that many incoming samples before storing any, so the output resumes at the time point it would have reached without the gap. This keeps phase coherent rather than shifting the waveform by the length of the gap.

Writes that find the store full are dropped and flagged. The block reports the fill level and whether occupancy has reached the 80 % flow-control target, so a host-side reporter can pace the sender. The depth is a power-of-two parameter. A production build uses 65,536 entries, and small values are used for tests.

Top module: `tx_sample_buffer`

## Requirements
- R1: Stored samples leave in arrival order, one per strobe, on `out_data` with `out_valid` high in the cycle after the strobe.
- R2: A strobe that finds the store empty while `fill_hold` is 0 produces `out_data` = 0 in the next cycle.
- R3: A strobe that finds the store empty while `fill_hold` is 1 produces the last real sample that was output (0 if none has been output since reset).
- R4: Each inserted fill sample increments a skip count, and each arriving sample while the skip count is non-zero is discarded instead of stored, decrementing the count.
- R5: `underflow` is high for exactly the cycle that carries a fill sample; `underflow_seen` is set with it and holds until `clr_status` is pulsed.
- R6: A sample arriving while the store holds DEPTH entries is discarded; `level` stays at DEPTH.
- R7: A discarded-on-full write raises `overflow` for one cycle and sets `overflow_seen` until `clr_status`.
- R8: `above_target` is 1 exactly when level*5 >= DEPTH*4 (level 7 and above for DEPTH 8).
- R9: A stored write and a real read in the same cycle leave `level` unchanged.
- R10: The skip count saturates at 2^SKIP_W-1 instead of wrapping.
- R11: A sample arriving in the same cycle as a fill insertion is discarded as the late sample for that slot.
- R12: After reset, `level` is 0, all flags are 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming sample present |
| in_data | input | 32 | Incoming complex sample |
| strobe | input | 1 | DAC sample-enable |
| fill_hold | input | 1 | 0: zero fill, 1: repeat last sample |
| clr_status | input | 1 | Clears the sticky status bits |
| out_valid | output | 1 | Output sample updated this cycle |
| out_data | output | 32 | Sample to the DAC |
| underflow | output | 1 | Current output is a fill sample |
| underflow_seen | output | 1 | Sticky underflow |
| overflow | output | 1 | A write was dropped on full |
| overflow_seen | output | 1 | Sticky overflow |
| level | output | $clog2(DEPTH)+1 | Stored sample count |
| above_target | output | 1 | Occupancy at or above 80 % |

## Verification
The bench runs an underflow gap followed by a burst of late data. A design that stored the late samples, or skipped the wrong number, would output the wrong words after the gap. It runs repeat mode across two gaps, a write that collides with a fill insertion, and a strobe that coincides with a write. Without the collision rule, a sample would be stored one slot late; without the coincidence rule, the level would drift. It also pushes past a full store and inserts more fills than the skip counter can hold. A design that wrapped the counter would then store far too many or too few late samples.

// File: rtl/tsb_pkg.sv
// Shared types for the transmit sample buffer.
// Assumes a 32-bit packed complex sample (I and Q halves).
package tsb_pkg;
    localparam int SAMPLE_W = 32;
    typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/tsb_store.sv
// Sample store: circular buffer with occupancy count.
// Assumes DEPTH is a power of two; caller never pops when empty.
// A write while full is ignored here (the caller flags it).
module tsb_store
    import tsb_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  sample_t wr_data,
    input  logic    rd_en,
    output sample_t rd_data,
    output logic [AW:0] count,
    output logic    empty,
    output logic    full
);
    sample_t       mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign rd_data = mem[rd_ptr];

    // Write sample array (no reset on storage).
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            case ({do_wr, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
    assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);
    assert_rw_same_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && rd_en) |=> $stable(count));
    assert_no_pop_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && empty));
endmodule

// File: rtl/tsb_skip_ctrl.sv
// Late-sample skip control: counts inserted fill samples and
// decides which arriving samples are dropped to restore timing.
// Assumes fill_evt is a single-cycle event per inserted fill.
module tsb_skip_ctrl #(
    parameter int SKIP_W = 16,
    localparam logic [SKIP_W-1:0] SKIP_MAX = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic fill_evt,
    output logic discard
);
    logic [SKIP_W-1:0] skip_cnt;
    logic              pending;

    assign pending = (skip_cnt != '0);
    // A sample arriving with a fill insertion is the late sample for that slot.
    assign discard = in_valid && (pending || fill_evt);

    // Update skip count: +1 per fill, -1 per discard, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_cnt <= '0;
        end else if (fill_evt && !discard) begin
            if (skip_cnt != SKIP_MAX) skip_cnt <= skip_cnt + 1'b1;
        end else if (!fill_evt && discard) begin
            skip_cnt <= skip_cnt - 1'b1;
        end
    end

    assert_skip_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_cnt == SKIP_MAX && fill_evt && !in_valid) |=> skip_cnt == SKIP_MAX);
    assert_skip_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && in_valid && !fill_evt) |=> skip_cnt == $past(skip_cnt) - 1'b1);
endmodule

// File: rtl/tsb_out_stage.sv
// Output register toward the DAC: selects stored or fill sample,
// remembers the last real sample and holds the status flags.
// Assumes fill_evt and rd_en are mutually exclusive.
module tsb_out_stage
    import tsb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rd_en,
    input  logic    fill_evt,
    input  sample_t rd_data,
    input  logic    fill_hold,
    input  logic    ovf_evt,
    input  logic    clr_status,
    output logic    out_valid,
    output sample_t out_data,
    output logic    underflow,
    output logic    underflow_seen,
    output logic    overflow,
    output logic    overflow_seen
);
    sample_t last_real;

    // Register the DAC sample and remember the last real one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            last_real <= '0;
        end else begin
            out_valid <= rd_en || fill_evt;
            if (rd_en) begin
                out_data  <= rd_data;
                last_real <= rd_data;
            end else if (fill_evt) begin
                out_data <= fill_hold ? last_real : '0;
            end
        end
    end

    // Event pulses and sticky status; a new event wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underflow      <= 1'b0;
            overflow       <= 1'b0;
            underflow_seen <= 1'b0;
            overflow_seen  <= 1'b0;
        end else begin
            underflow <= fill_evt;
            overflow  <= ovf_evt;
            if (fill_evt)        underflow_seen <= 1'b1;
            else if (clr_status) underflow_seen <= 1'b0;
            if (ovf_evt)         overflow_seen  <= 1'b1;
            else if (clr_status) overflow_seen  <= 1'b0;
        end
    end

    assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_evt && !fill_hold) |=> (out_data == '0 && underflow));
    assert_sticky_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> underflow_seen);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> overflow_seen);
    assert_real_not_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (out_valid && !underflow));
endmodule

// File: rtl/tx_sample_buffer.sv
// Transmit sample buffer toward a strobed DAC, tolerant of host gaps.
// Fills underflow slots, drops the matching late samples, drops writes
// when full, and reports occupancy against an 80 % target.
// Assumes DEPTH is a power of two.
module tx_sample_buffer
    import tsb_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int SKIP_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int TGT   = (4 * DEPTH + 4) / 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   in_data,
    input  logic          strobe,
    input  logic          fill_hold,
    input  logic          clr_status,
    output logic          out_valid,
    output logic [31:0]   out_data,
    output logic          underflow,
    output logic          underflow_seen,
    output logic          overflow,
    output logic          overflow_seen,
    output logic [AW:0]   level,
    output logic          above_target
);
    logic    empty, full, discard, fill_evt, rd_en, wr_en, ovf_evt;
    sample_t rd_data, out_q;

    assign fill_evt     = strobe && empty;
    assign rd_en        = strobe && !empty;
    assign wr_en        = in_valid && !discard && !full;
    assign ovf_evt      = in_valid && !discard && full;
    assign above_target = (level >= (AW+1)'(TGT));
    assign out_data     = out_q;

    tsb_skip_ctrl #(.SKIP_W(SKIP_W)) skip_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .fill_evt(fill_evt), .discard(discard)
    );

    tsb_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(in_data),
        .rd_en(rd_en), .rd_data(rd_data), .count(level),
        .empty(empty), .full(full)
    );

    tsb_out_stage out_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .fill_evt(fill_evt),
        .rd_data(rd_data), .fill_hold(fill_hold), .ovf_evt(ovf_evt),
        .clr_status(clr_status), .out_valid(out_valid), .out_data(out_q),
        .underflow(underflow), .underflow_seen(underflow_seen),
        .overflow(overflow), .overflow_seen(overflow_seen)
    );

    assert_target_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !above_target);
    assert_drop_on_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && in_valid && !strobe) |=> full);
endmodule

// File: tb/tx_sample_buffer_tb.sv
module tx_sample_buffer_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8;
    localparam int SKIP_W = 3;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, strobe = 0, fill_hold = 0, clr_status = 0;
    logic [31:0] in_data = 0;
    logic out_valid, underflow, underflow_seen, overflow, overflow_seen, above_target;
    logic [31:0] out_data;
    logic [3:0] level;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    tx_sample_buffer #(.DEPTH(DEPTH), .SKIP_W(SKIP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .strobe(strobe), .fill_hold(fill_hold), .clr_status(clr_status),
        .out_valid(out_valid), .out_data(out_data), .underflow(underflow),
        .underflow_seen(underflow_seen), .overflow(overflow),
        .overflow_seen(overflow_seen), .level(level), .above_target(above_target)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Each helper starts and ends just after a falling edge.
    task automatic push(logic [31:0] v);
        in_valid = 1; in_data = v;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic pull();
        strobe = 1;
        @(negedge clk);
        strobe = 0;
    endtask

    task automatic pull_expect(string req, logic [31:0] v, logic uf);
        pull();
        chk(req, out_valid, 1);
        chk(req, out_data, v);
        chk(req, underflow, uf);
    endtask

    task automatic t_reset();
        chk("R12 level", level, 0);
        chk("R12 out_valid", out_valid, 0);
        chk("R12 flags", {underflow, underflow_seen, overflow, overflow_seen, above_target}, 0);
    endtask

    task automatic t_order();
        push(32'h11); push(32'h22); push(32'h33);
        chk("R1 level", level, 3);
        pull_expect("R1", 32'h11, 0);
        pull_expect("R1", 32'h22, 0);
        pull_expect("R1", 32'h33, 0);
        chk("R1 level drained", level, 0);
    endtask

    task automatic t_zero_fill();
        pull_expect("R2 zero fill", 32'h0, 1);
        chk("R5 sticky set", underflow_seen, 1);
        @(negedge clk);
        chk("R5 pulse one cycle", underflow, 0);
        chk("R5 sticky holds", underflow_seen, 1);
    endtask

    task automatic t_skip();
        pull_expect("R4 second fill", 32'h0, 1);
        push(32'hA1); push(32'hA2); push(32'hA3); push(32'hA4);
        chk("R4 late dropped", level, 2);
        pull_expect("R4 resume", 32'hA3, 0);
        pull_expect("R4 resume", 32'hA4, 0);
    endtask

    task automatic t_hold();
        fill_hold = 1;
        pull_expect("R3 hold fill", 32'hA4, 1);
        push(32'hB0);
        chk("R4 hold skip", level, 0);
        push(32'hB1);
        pull_expect("R3 real", 32'hB1, 0);
        pull_expect("R3 hold fill 2", 32'hB1, 1);
        push(32'hB2);
        chk("R4 hold skip 2", level, 0);
        fill_hold = 0;
    endtask

    task automatic t_clear();
        clr_status = 1;
        @(negedge clk);
        clr_status = 0;
        chk("R5 sticky cleared", underflow_seen, 0);
    endtask

    task automatic t_full_target();
        for (int i = 0; i < 6; i++) push(32'hC0 + i);
        chk("R8 level 6", level, 6);
        chk("R8 below target", above_target, 0);
        push(32'hC6);
        chk("R8 at target", above_target, 1);
        push(32'hC7);
        chk("R6 full", level, 8);
        push(32'hC8);
        chk("R7 overflow pulse", overflow, 1);
        chk("R7 overflow sticky", overflow_seen, 1);
        chk("R6 level stays", level, 8);
        @(negedge clk);
        chk("R7 pulse one cycle", overflow, 0);
    endtask

    task automatic t_simul();
        pull_expect("R1 after full", 32'hC0, 0);
        chk("R9 level before", level, 7);
        in_valid = 1; in_data = 32'hD0; strobe = 1;
        @(negedge clk);
        in_valid = 0; strobe = 0;
        chk("R9 simul out", out_data, 32'hC1);
        chk("R9 level same", level, 7);
        for (int i = 2; i < 8; i++) pull_expect("R6 drain", 32'hC0 + i, 0);
        pull_expect("R6 no C8 stored", 32'hD0, 0);
        chk("R6 drained", level, 0);
    endtask

    task automatic t_collide();
        in_valid = 1; in_data = 32'hE0; strobe = 1;
        @(negedge clk);
        in_valid = 0; strobe = 0;
        chk("R11 fill out", out_data, 0);
        chk("R11 flagged", underflow, 1);
        chk("R11 dropped", level, 0);
        push(32'hE1);
        chk("R11 next stored", level, 1);
        pull_expect("R11 next", 32'hE1, 0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 9; i++) pull();
        for (int i = 0; i < 8; i++) push(32'hF0 + i);
        chk("R10 saturated skip", level, 1);
        pull_expect("R10 resume", 32'hF7, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_order();
        t_zero_fill();
        t_skip();
        t_hold();
        t_clear();
        t_full_target();
        t_simul();
        t_collide();
        t_saturate();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule